// File: doc/BRIEF.md
# Dual-Rate Memory Read Port with Write Forwarding

This block is the read side of a memory with separate data-in and data-out paths and double-rate transfers. It runs on one fast system clock. Each rising edge of that clock is one event slot of the external interface. Single-cycle strobes mark which slots are rising edges of the input clock pair (K, K#) and which are rising edges of the output clock pair (C, C#). A read request and its address are taken on a K slot. The block fetches a full 36-bit word and returns it as two 18-bit halves: the lower half on a C slot, the upper half on the following C# slot.

The write side presents an already assembled 36-bit word with four 9-bit lane strobes on the same K slot. A read that starts on the same K slot at the same address returns the new lanes merged over the stored word. A write started one K cycle after a read is not seen by that read. The block decides by itself when the output is driven, and it flags this with a registered drive-enable beside the data.

A strap, sampled only while reset is asserted, selects single-clock operation. In that mode the K and K# slots take the place of the C and C# slots, and the C strobes are ignored.

Top module: `rdp_read_port`

## Requirements
- R1: During and directly after reset, q_drive is 0 and q_data is 0.
- R2: rd_en_n, rd_addr and all write inputs act only in slots where k_rise is 1. Values in any other slot, including an active enable, change neither the memory nor the outputs.
- R3: In dual-clock mode, a read accepted at one K slot is output on the first C slot after the next K slot, with q_drive 1 and q_data = word[17:0]. q_data holds until the next C# slot, where it shows word[35:18].
- R4: Reads accepted on consecutive K slots produce back-to-back bursts, with no gap in q_drive between them.
- R5: If no read was accepted at the K slot that feeds a C slot, that C slot sets q_drive to 0. A burst already under way still completes. While q_drive is 0, q_data is 0.
- R6: If a write is accepted at the same K slot and at the same address as a read, the read returns each lane from the write data when that lane's strobe is active, and from the stored word otherwise. Lane i is bits [9i+8:9i], and wr_lane_n[i]=0 enables it.
- R7: A write to the same address accepted at the K slot after a read does not change the data that read returns.
- R8: A write to a different address in the same K slot does not affect the read data.
- R9: single_clk_strap is sampled only during reset. When it is 1, K slots act as C slots and K# slots act as C# slots, so a read accepted at one K slot shows its lower half at the K slot after next and its upper half at the K# slot that follows. c_rise and cn_rise are ignored.
- R10: A write updates only the lanes whose strobes are active. The other lanes keep their stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one interface event slot per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| single_clk_strap | input | 1 | Clock-mode strap, captured during reset |
| k_rise | input | 1 | This slot is a rising edge of K |
| kn_rise | input | 1 | This slot is a rising edge of K# |
| c_rise | input | 1 | This slot is a rising edge of C |
| cn_rise | input | 1 | This slot is a rising edge of C# |
| rd_en_n | input | 1 | Active-low read request |
| rd_addr | input | ADDR_W | Read word address |
| wr_en_n | input | 1 | Active-low write request |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 36 | Assembled write word |
| wr_lane_n | input | 4 | Active-low 9-bit lane strobes |
| q_data | output | 18 | Output half-word |
| q_drive | output | 1 | Registered output drive enable |

## Verification
A wrong pipeline-valid bit shows up at the first C slot after the following K slot. The drive flag then rises where it should stay low, or drops in the middle of a stream. A wrong forwarding decision or a lost lane strobe shows up as a wrong 9-bit field in the lower or upper half one K cycle after the read. A stale upper-half register is seen at the very next C# slot, and a mis-latched clock-mode strap shifts every burst by one K cycle from the first read after reset.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;
    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } word_t;

    typedef struct packed {
        logic  vld;
        word_t data;
    } stage_t;

    function automatic word_t lane_merge(word_t old_w, word_t new_w,
                                         logic [LANES-1:0] take);
        logic [WORD_W-1:0] res;
        res = old_w;
        for (int l = 0; l < LANES; l++) begin
            if (take[l]) res[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
        end
        return word_t'(res);
    endfunction
endpackage

// File: rtl/rdp_array.sv
module rdp_array
    import rdp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic [LANES-1:0]  wlane_en,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= lane_merge(mem[waddr], wdata, wlane_en);
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rdp_fetch.sv
module rdp_fetch
    import rdp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              k_ev,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic [LANES-1:0]  wr_lane_en,
    input  word_t             arr_rdata,
    output stage_t            burst
);
    stage_t s1, s2;
    word_t  snap;
    logic   fwd_hit;

    assign fwd_hit = wr_req && (wr_addr == rd_addr);
    assign snap    = fwd_hit ? lane_merge(arr_rdata, wr_data, wr_lane_en) : arr_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else if (k_ev) begin
            s1 <= '{vld: rd_req, data: snap};
            s2 <= s1;
        end
    end

    assign burst = s2;
endmodule

// File: rtl/rdp_outseq.sv
module rdp_outseq
    import rdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              c_ev,
    input  logic              cn_ev,
    input  stage_t            burst,
    output logic [HALF_W-1:0] q_data,
    output logic              q_drive
);
    logic [HALF_W-1:0] hi_hold;
    logic              hi_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_data  <= '0;
            q_drive <= 1'b0;
            hi_hold <= '0;
            hi_pend <= 1'b0;
        end else if (c_ev) begin
            if (burst.vld) begin
                q_data  <= burst.data.lo;
                q_drive <= 1'b1;
                hi_hold <= burst.data.hi;
                hi_pend <= 1'b1;
            end else begin
                q_data  <= '0;
                q_drive <= 1'b0;
                hi_pend <= 1'b0;
            end
        end else if (cn_ev && hi_pend) begin
            q_data  <= hi_hold;
            hi_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/rdp_read_port.sv
module rdp_read_port
    import rdp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      single_clk_strap,
    input  logic                      k_rise,
    input  logic                      kn_rise,
    input  logic                      c_rise,
    input  logic                      cn_rise,
    input  logic                      rd_en_n,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic                      wr_en_n,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [rdp_pkg::WORD_W-1:0] wr_data,
    input  logic [rdp_pkg::LANES-1:0] wr_lane_n,
    output logic [rdp_pkg::HALF_W-1:0] q_data,
    output logic                      q_drive
);
    logic   mode_single;
    logic   c_ev, cn_ev, rd_req, wr_req, burst_vld;
    word_t  arr_rdata;
    stage_t burst;

    always_ff @(posedge clk) begin
        if (rst) mode_single <= single_clk_strap;
    end

    assign c_ev      = mode_single ? k_rise  : c_rise;
    assign cn_ev     = mode_single ? kn_rise : cn_rise;
    assign rd_req    = k_rise && !rd_en_n;
    assign wr_req    = k_rise && !wr_en_n;
    assign burst_vld = burst.vld;

    rdp_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .we       (wr_req),
        .waddr    (wr_addr),
        .wdata    (word_t'(wr_data)),
        .wlane_en (~wr_lane_n),
        .raddr    (rd_addr),
        .rdata    (arr_rdata)
    );

    rdp_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .k_ev       (k_rise),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (word_t'(wr_data)),
        .wr_lane_en (~wr_lane_n),
        .arr_rdata  (arr_rdata),
        .burst      (burst)
    );

    rdp_outseq u_outseq (
        .clk     (clk),
        .rst     (rst),
        .c_ev    (c_ev),
        .cn_ev   (cn_ev),
        .burst   (burst),
        .q_data  (q_data),
        .q_drive (q_drive)
    );
endmodule

// File: rtl/rdp_checker.sv
module rdp_checker #(
    parameter int HW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          c_ev,
    input logic          cn_ev,
    input logic          s2_vld,
    input logic [HW-1:0] q_data,
    input logic          q_drive
);
    p_quiet_bus_r5: assert property (@(posedge clk) disable iff (rst)
        !q_drive |-> q_data == '0);

    p_drive_moves_on_c_r5: assert property (@(posedge clk) disable iff (rst)
        !c_ev |=> $stable(q_drive));

    p_start_needs_burst_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(q_drive) |-> $past(s2_vld));

    p_hold_between_edges_r3: assert property (@(posedge clk) disable iff (rst)
        (!c_ev && !cn_ev) |=> $stable(q_data));

    p_drive_after_vld_r4: assert property (@(posedge clk) disable iff (rst)
        (c_ev && s2_vld) |=> q_drive);
endmodule

bind rdp_read_port rdp_checker #(.HW(rdp_pkg::HALF_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .c_ev    (c_ev),
    .cn_ev   (cn_ev),
    .s2_vld  (burst_vld),
    .q_data  (q_data),
    .q_drive (q_drive)
);

// File: tb/tb_rdp_read_port.sv
module tb_rdp_read_port;
    logic        clk = 1'b0;
    logic        rst, single_clk_strap;
    logic        k_rise, kn_rise, c_rise, cn_rise;
    logic        rd_en_n, wr_en_n;
    logic [3:0]  rd_addr, wr_addr, wr_lane_n;
    logic [35:0] wr_data;
    logic [17:0] q_data;
    logic        q_drive;

    int n_checks = 0;
    int n_errors = 0;

    rdp_read_port #(.ADDR_W(4)) dut (
        .clk(clk), .rst(rst), .single_clk_strap(single_clk_strap),
        .k_rise(k_rise), .kn_rise(kn_rise), .c_rise(c_rise), .cn_rise(cn_rise),
        .rd_en_n(rd_en_n), .rd_addr(rd_addr), .wr_en_n(wr_en_n), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_lane_n(wr_lane_n), .q_data(q_data), .q_drive(q_drive)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic        rd_n;
        logic [3:0]  raddr;
        logic        wr_n;
        logic [3:0]  waddr;
        logic [35:0] wdata;
        logic [3:0]  wlane_n;
        logic [3:0]  tag;
    } vec_t;

    localparam vec_t DUAL_TBL [16] = '{
        '{1'b1, 4'd0, 1'b0, 4'd1, 36'h1_2345_6789, 4'h0, 4'd0},
        '{1'b1, 4'd0, 1'b0, 4'd2, 36'h8_7654_3210, 4'h0, 4'd0},
        '{1'b1, 4'd0, 1'b0, 4'd3, 36'hA_BCDE_F012, 4'h0, 4'd0},
        '{1'b0, 4'd1, 1'b1, 4'd0, 36'h0,           4'hF, 4'd3},
        '{1'b0, 4'd2, 1'b1, 4'd0, 36'h0,           4'hF, 4'd4},
        '{1'b0, 4'd3, 1'b0, 4'd3, 36'h5_5555_5555, 4'h5, 4'd6},
        '{1'b0, 4'd2, 1'b1, 4'd0, 36'h0,           4'hF, 4'd7},
        '{1'b1, 4'd0, 1'b0, 4'd2, 36'hF_0F0F_0F0F, 4'h0, 4'd0},
        '{1'b1, 4'd0, 1'b1, 4'd0, 36'h0,           4'hF, 4'd0},
        '{1'b1, 4'd0, 1'b1, 4'd0, 36'h0,           4'hF, 4'd0},
        '{1'b0, 4'd2, 1'b1, 4'd0, 36'h0,           4'hF, 4'd2},
        '{1'b1, 4'd0, 1'b0, 4'd1, 36'hC_CCCC_CCCC, 4'hE, 4'd0},
        '{1'b0, 4'd1, 1'b0, 4'd5, 36'h3_3333_3333, 4'h0, 4'd10},
        '{1'b0, 4'd3, 1'b0, 4'd7, 36'h7_7777_7777, 4'h0, 4'd8},
        '{1'b0, 4'd5, 1'b1, 4'd0, 36'h0,           4'hF, 4'd2},
        '{1'b1, 4'd0, 1'b1, 4'd0, 36'h0,           4'hF, 4'd0}
    };

    localparam vec_t SINGLE_TBL [8] = '{
        '{1'b1, 4'd0, 1'b0, 4'd6, 36'h9_8765_4321, 4'h0, 4'd0},
        '{1'b0, 4'd6, 1'b1, 4'd0, 36'h0,           4'hF, 4'd9},
        '{1'b0, 4'd1, 1'b1, 4'd0, 36'h0,           4'hF, 4'd9},
        '{1'b1, 4'd0, 1'b1, 4'd0, 36'h0,           4'hF, 4'd0},
        '{1'b1, 4'd0, 1'b1, 4'd0, 36'h0,           4'hF, 4'd0},
        '{1'b0, 4'd6, 1'b0, 4'd6, 36'h0,           4'h3, 4'd9},
        '{1'b1, 4'd0, 1'b1, 4'd0, 36'h0,           4'hF, 4'd0},
        '{1'b1, 4'd0, 1'b1, 4'd0, 36'h0,           4'hF, 4'd0}
    };

    logic [35:0] model_mem [16];
    logic        hist_rd  [2];
    logic [35:0] hist_w   [2];
    logic [3:0]  hist_tag [2];
    logic [17:0] sd [4];
    logic        sv [4];

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [35:0] merge_m(input logic [35:0] old_w, new_w,
                                            input logic [3:0] lanes_n);
        logic [35:0] r = old_w;
        for (int l = 0; l < 4; l++)
            if (!lanes_n[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
        return r;
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic k, kn, c, cn, input int i);
        k_rise = k; kn_rise = kn; c_rise = c; cn_rise = cn;
        @(posedge clk);
        #1;
        sd[i] = q_data;
        sv[i] = q_drive;
    endtask

    task automatic run_cycle(input vec_t v, input logic single);
        int s_lo  = single ? 0 : 1;
        int s_mid = single ? 1 : 2;
        int s_hi  = single ? 2 : 3;
        logic        e_rd  = single ? hist_rd[1]  : hist_rd[0];
        logic [35:0] e_w   = single ? hist_w[1]   : hist_w[0];
        logic [3:0]  e_tag = single ? hist_tag[1] : hist_tag[0];
        logic [35:0] rd_word;
        rd_en_n = v.rd_n; rd_addr = v.raddr; wr_en_n = v.wr_n;
        wr_addr = v.waddr; wr_data = v.wdata; wr_lane_n = v.wlane_n;
        tick(1'b1, 1'b0, single, single, 0);
        // R2: junk with active enables outside K slots
        rd_en_n = 1'b0; rd_addr = ~v.raddr; wr_en_n = 1'b0;
        wr_addr = ~v.waddr; wr_data = 36'hD_EADB_EEF0; wr_lane_n = 4'h0;
        tick(1'b0, 1'b0, 1'b1, single, 1);
        tick(1'b0, 1'b1, single, single, 2);
        tick(1'b0, 1'b0, single, 1'b1, 3);
        if (e_rd) begin
            chk(sv[s_lo] == 1'b1, single ? "R9" : "R4", 36'(sv[s_lo]), 36'd1);
            chk(sd[s_lo] == e_w[17:0], tag_name(e_tag), 36'(sd[s_lo]), 36'(e_w[17:0]));
            chk(sd[s_mid] == e_w[17:0], single ? "R9" : "R3", 36'(sd[s_mid]), 36'(e_w[17:0]));
            chk(sd[s_hi] == e_w[35:18], tag_name(e_tag), 36'(sd[s_hi]), 36'(e_w[35:18]));
        end else begin
            chk(sv[s_lo] == 1'b0, "R5", 36'(sv[s_lo]), 36'd0);
            chk(sd[s_lo] == 18'd0, "R5", 36'(sd[s_lo]), 36'd0);
        end
        rd_word = merge_m(model_mem[v.raddr], v.wdata,
                          (!v.wr_n && v.waddr == v.raddr) ? v.wlane_n : 4'hF);
        if (!v.wr_n) model_mem[v.waddr] = merge_m(model_mem[v.waddr], v.wdata, v.wlane_n);
        hist_rd[1] = hist_rd[0]; hist_w[1] = hist_w[0]; hist_tag[1] = hist_tag[0];
        hist_rd[0] = !v.rd_n;    hist_w[0] = rd_word;   hist_tag[0] = v.tag;
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1; single_clk_strap = strap;
        rd_en_n = 1'b1; wr_en_n = 1'b1; rd_addr = '0; wr_addr = '0;
        wr_data = '0; wr_lane_n = 4'hF;
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b0, 1'b0, 0);
        // R1: state held in reset
        chk(q_drive == 1'b0 && q_data == 18'd0, "R1", {17'd0, q_drive, q_data}, 36'd0);
        rst = 1'b0;
        tick(1'b0, 1'b0, 1'b0, 1'b0, 0);
        chk(q_drive == 1'b0 && q_data == 18'd0, "R1", {17'd0, q_drive, q_data}, 36'd0);
        for (int i = 0; i < 2; i++) begin
            hist_rd[i] = 1'b0; hist_w[i] = '0; hist_tag[i] = '0;
        end
    endtask

    initial begin
        k_rise = 0; kn_rise = 0; c_rise = 0; cn_rise = 0;
        for (int i = 0; i < 16; i++) model_mem[i] = '0;
        do_reset(1'b0);
        for (int i = 0; i < 16; i++) run_cycle(DUAL_TBL[i], 1'b0);
        // R9: strap is taken in reset only; change it afterwards
        do_reset(1'b1);
        single_clk_strap = 1'b0;
        for (int i = 0; i < 8; i++) run_cycle(SINGLE_TBL[i], 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule